// File: doc/BRIEF.md
# Single-Cycle Move/Load/Jump Processor Core

This core executes a small byte-encoded 64-bit instruction subset, one whole instruction per clock. Each cycle it reads a window of up to ten bytes at the program counter from an internal byte-wide instruction store. It splits off the opcode byte and the register-specifier byte, reads up to two of its fifteen 64-bit registers, and forms an address or a result with a single adder. A load then reads eight bytes from an internal data store. Results are written back at the clock edge, and the program counter advances by the instruction's length or takes a jump target.

The two stores are filled through a byte-wide loader port, normally while reset is held. Software-visible state is observed through the program-counter output, two status flags and a combinational register view port. Reset is asynchronous and active low, and it must be deasserted in step with the clock. Instruction and data store sizes must be powers of two. All multi-byte constants are little-endian.

Top module: `subset_cpu_core`

## Requirements
- R1: While reset is low and on the first cycle after it, the program counter is 0, both status flags are low and every register reads 0.
- R2: One instruction completes per rising clock edge while running. Opcode byte 0x10 (no-op) is 1 byte long and changes nothing but the PC, 0x20 is 2 bytes long, and 0x30 and 0x50 are 10 bytes long. The next PC is the current PC plus that length.
- R3: Opcode 0x70 is a 9-byte jump: the next PC is the little-endian 64-bit value in bytes 1..8 of the instruction.
- R4: Opcode 0x20 copies register A to register B. Byte 1 holds A in bits 7:4 and B in bits 3:0.
- R5: Opcode 0x30 writes the little-endian 64-bit constant in bytes 2..9 into register B, the low nibble of byte 1.
- R6: Opcode 0x50 adds register B to the little-endian displacement in bytes 2..9. It reads eight consecutive data bytes starting at that sum modulo the data store size, wrapping past the top, and writes them little-endian into register A.
- R7: Specifier 0xF names no register. As a source it reads 0, as a destination the write is dropped, and the view port returns 0 for it.
- R8: Opcode 0x00 raises the halted flag. The PC stays at the halt instruction's address and no register changes afterwards.
- R9: Any opcode byte other than 0x00, 0x10, 0x20, 0x30, 0x50 and 0x70 raises the invalid-instruction flag. The PC stays at that instruction and no register is written.
- R10: The halted and invalid flags are never both high. Once either is set it holds until reset.
- R11: The view port shows the current content of the register it selects, within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| ld_en_i | input | 1 | Loader write strobe for one byte |
| ld_dmem_i | input | 1 | Loader target: 1 selects the data store, 0 the instruction store |
| ld_addr_i | input | LD_AW (9) | Loader byte address |
| ld_data_i | input | 8 | Loader byte value |
| dbg_sel_i | input | 4 | Register selected for viewing |
| dbg_val_o | output | 64 | Content of the selected register |
| pc_o | output | 64 | Current program counter |
| halted_o | output | 1 | Halt instruction reached |
| bad_instr_o | output | 1 | Unsupported opcode reached |

## Verification
The bench sweeps all 256 values of the first opcode byte after reset. This separates the six legal opcodes from every near miss that shares a nibble with them, such as 0x21 or 0x51. A core that decoded only the high nibble would advance on such bytes instead of stopping. A straight-line program writes all fifteen registers with distinct constants. It then moves through the null specifier as both source and destination, loads at a data address that wraps past the top of the store, and jumps over a poisoned instruction. Wrong length arithmetic would change the cycle count to halt or the final PC. A misplaced constant window would corrupt the loaded values, and a dropped null check would overwrite register 14 or leak a stale value. A mid-program invalid byte checks that the core freezes without letting the following instruction write.

// File: rtl/subset_cpu_pkg.sv
package subset_cpu_pkg;

  localparam int XLEN        = 64;
  localparam int SPEC_W      = 4;
  localparam int NUM_REGS    = (1 << SPEC_W) - 1;
  localparam int FETCH_BYTES = 10;
  localparam int CONST_BYTES = XLEN / 8;
  localparam int LEN_W       = 4;

  localparam logic [SPEC_W-1:0] NULL_REG = '1;

  localparam logic [7:0] OPB_HALT  = 8'h00;
  localparam logic [7:0] OPB_NOP   = 8'h10;
  localparam logic [7:0] OPB_RRMOV = 8'h20;
  localparam logic [7:0] OPB_IRMOV = 8'h30;
  localparam logic [7:0] OPB_LOAD  = 8'h50;
  localparam logic [7:0] OPB_JUMP  = 8'h70;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HALT = 2'd1,
    ST_BAD  = 2'd2
  } core_state_e;

  typedef struct packed {
    logic [SPEC_W-1:0] src_a;
    logic [SPEC_W-1:0] src_b;
    logic [SPEC_W-1:0] dst_e;
    logic [SPEC_W-1:0] dst_m;
    logic              a_const;
    logic              jump;
    logic [LEN_W-1:0]  len;
    logic              stop_halt;
    logic              stop_bad;
  } ctl_t;

endpackage

// File: rtl/cpu_fetch.sv
module cpu_fetch
  import subset_cpu_pkg::*;
#(
  parameter  int IMEM_BYTES = 512,
  localparam int IA_W       = $clog2(IMEM_BYTES)
) (
  input  logic                              clk_i,
  input  logic                              ld_we_i,
  input  logic [IA_W-1:0]                   ld_addr_i,
  input  logic [7:0]                        ld_data_i,
  input  logic [IA_W-1:0]                   pc_i,
  output logic [FETCH_BYTES-1:0][7:0]       bytes_o
);

  logic [7:0] mem [IMEM_BYTES];

  always_ff @(posedge clk_i) begin
    if (ld_we_i) begin
      mem[ld_addr_i] <= ld_data_i;
    end
  end

  for (genvar k = 0; k < FETCH_BYTES; k++) begin : g_win
    logic [IA_W-1:0] idx;
    assign idx        = pc_i + IA_W'(k);
    assign bytes_o[k] = mem[idx];
  end

endmodule

// File: rtl/cpu_decode.sv
module cpu_decode
  import subset_cpu_pkg::*;
(
  input  logic [7:0] op_i,
  input  logic [7:0] spec_i,
  output ctl_t       ctl_o
);

  logic [SPEC_W-1:0] ra;
  logic [SPEC_W-1:0] rb;

  assign ra = spec_i[7:4];
  assign rb = spec_i[3:0];

  always_comb begin
    ctl_o           = '0;
    ctl_o.src_a     = NULL_REG;
    ctl_o.src_b     = NULL_REG;
    ctl_o.dst_e     = NULL_REG;
    ctl_o.dst_m     = NULL_REG;
    ctl_o.len       = LEN_W'(1);
    case (op_i)
      OPB_HALT: ctl_o.stop_halt = 1'b1;
      OPB_NOP:  ctl_o.len = LEN_W'(1);
      OPB_RRMOV: begin
        ctl_o.src_a = ra;
        ctl_o.dst_e = rb;
        ctl_o.len   = LEN_W'(2);
      end
      OPB_IRMOV: begin
        ctl_o.a_const = 1'b1;
        ctl_o.dst_e   = rb;
        ctl_o.len     = LEN_W'(10);
      end
      OPB_LOAD: begin
        ctl_o.a_const = 1'b1;
        ctl_o.src_b   = rb;
        ctl_o.dst_m   = ra;
        ctl_o.len     = LEN_W'(10);
      end
      OPB_JUMP: begin
        ctl_o.jump = 1'b1;
        ctl_o.len  = LEN_W'(9);
      end
      default:  ctl_o.stop_bad = 1'b1;
    endcase
  end

endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile
  import subset_cpu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SPEC_W-1:0] src_a_i,
  input  logic [SPEC_W-1:0] src_b_i,
  input  logic [SPEC_W-1:0] dst_e_i,
  input  logic [SPEC_W-1:0] dst_m_i,
  input  logic [XLEN-1:0]   val_e_i,
  input  logic [XLEN-1:0]   val_m_i,
  input  logic [SPEC_W-1:0] dbg_sel_i,
  output logic [XLEN-1:0]   rd_a_o,
  output logic [XLEN-1:0]   rd_b_o,
  output logic [XLEN-1:0]   dbg_o
);

  logic [NUM_REGS-1:0][XLEN-1:0] regs;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [XLEN-1:0] q;
    logic [XLEN-1:0] d;
    logic            en;

    // memory-side write port takes priority over the adder-side port
    always_comb begin
      en = 1'b0;
      d  = val_e_i;
      if (wr_en_i && (dst_e_i == SPEC_W'(i))) begin
        en = 1'b1;
        d  = val_e_i;
      end
      if (wr_en_i && (dst_m_i == SPEC_W'(i))) begin
        en = 1'b1;
        d  = val_m_i;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q <= '0;
      end else if (en) begin
        q <= d;
      end
    end

    assign regs[i] = q;
  end

  function automatic logic [XLEN-1:0] read_port(input logic [SPEC_W-1:0] sel);
    logic [XLEN-1:0] v;
    v = '0;
    for (int j = 0; j < NUM_REGS; j++) begin
      if (sel == SPEC_W'(j)) v = regs[j];
    end
    return v;
  endfunction

  assign rd_a_o = read_port(src_a_i);
  assign rd_b_o = read_port(src_b_i);
  assign dbg_o  = read_port(dbg_sel_i);

endmodule

// File: rtl/cpu_dmem.sv
module cpu_dmem
  import subset_cpu_pkg::*;
#(
  parameter  int DMEM_BYTES = 256,
  localparam int DA_W       = $clog2(DMEM_BYTES)
) (
  input  logic              clk_i,
  input  logic              ld_we_i,
  input  logic [DA_W-1:0]   ld_addr_i,
  input  logic [7:0]        ld_data_i,
  input  logic [DA_W-1:0]   addr_i,
  output logic [XLEN-1:0]   data_o
);

  logic [7:0] mem [DMEM_BYTES];

  always_ff @(posedge clk_i) begin
    if (ld_we_i) begin
      mem[ld_addr_i] <= ld_data_i;
    end
  end

  for (genvar k = 0; k < CONST_BYTES; k++) begin : g_rd
    logic [DA_W-1:0] idx;
    assign idx             = addr_i + DA_W'(k);
    assign data_o[8*k +: 8] = mem[idx];
  end

endmodule

// File: rtl/subset_cpu_core.sv
module subset_cpu_core
  import subset_cpu_pkg::*;
#(
  parameter  int IMEM_BYTES = 512,
  parameter  int DMEM_BYTES = 256,
  localparam int IA_W       = $clog2(IMEM_BYTES),
  localparam int DA_W       = $clog2(DMEM_BYTES),
  localparam int LD_AW      = (IA_W > DA_W) ? IA_W : DA_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_en_i,
  input  logic             ld_dmem_i,
  input  logic [LD_AW-1:0] ld_addr_i,
  input  logic [7:0]       ld_data_i,
  input  logic [3:0]       dbg_sel_i,
  output logic [63:0]      dbg_val_o,
  output logic [63:0]      pc_o,
  output logic             halted_o,
  output logic             bad_instr_o
);

  logic [XLEN-1:0]              pc_q, pc_d;
  logic                         pc_en;
  core_state_e                  state_q, state_d;
  logic                         state_en;
  logic [FETCH_BYTES-1:0][7:0]  ibytes;
  ctl_t                         ctl;
  logic                         running;
  logic                         commit;
  logic [XLEN-1:0]              jmp_tgt, imm;
  logic [XLEN-1:0]              rd_a, rd_b;
  logic [XLEN-1:0]              alu_a, val_e, val_m;

  cpu_fetch #(.IMEM_BYTES(IMEM_BYTES)) u_fetch (
    .clk_i     (clk_i),
    .ld_we_i   (ld_en_i && !ld_dmem_i),
    .ld_addr_i (ld_addr_i[IA_W-1:0]),
    .ld_data_i (ld_data_i),
    .pc_i      (pc_q[IA_W-1:0]),
    .bytes_o   (ibytes)
  );

  cpu_decode u_dec (
    .op_i   (ibytes[0]),
    .spec_i (ibytes[1]),
    .ctl_o  (ctl)
  );

  always_comb begin
    for (int k = 0; k < CONST_BYTES; k++) begin
      jmp_tgt[8*k +: 8] = ibytes[1 + k];
      imm[8*k +: 8]     = ibytes[2 + k];
    end
  end

  cpu_regfile u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (commit),
    .src_a_i   (ctl.src_a),
    .src_b_i   (ctl.src_b),
    .dst_e_i   (ctl.dst_e),
    .dst_m_i   (ctl.dst_m),
    .val_e_i   (val_e),
    .val_m_i   (val_m),
    .dbg_sel_i (dbg_sel_i),
    .rd_a_o    (rd_a),
    .rd_b_o    (rd_b),
    .dbg_o     (dbg_val_o)
  );

  // single adder: register move adds 0, immediate adds 0, load adds base
  assign alu_a = ctl.a_const ? imm : rd_a;
  assign val_e = alu_a + rd_b;

  cpu_dmem #(.DMEM_BYTES(DMEM_BYTES)) u_dmem (
    .clk_i     (clk_i),
    .ld_we_i   (ld_en_i && ld_dmem_i),
    .ld_addr_i (ld_addr_i[DA_W-1:0]),
    .ld_data_i (ld_data_i),
    .addr_i    (val_e[DA_W-1:0]),
    .data_o    (val_m)
  );

  // next-state logic
  assign running = (state_q == ST_RUN);
  assign commit  = running && !ctl.stop_halt && !ctl.stop_bad;
  assign pc_en   = commit;
  assign pc_d    = ctl.jump ? jmp_tgt : (pc_q + XLEN'(ctl.len));
  assign state_en = running;

  always_comb begin
    state_d = state_q;
    if (ctl.stop_halt) begin
      state_d = ST_HALT;
    end else if (ctl.stop_bad) begin
      state_d = ST_BAD;
    end
  end

  // state registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
    end else if (pc_en) begin
      pc_q <= pc_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  assign pc_o        = pc_q;
  assign halted_o    = (state_q == ST_HALT);
  assign bad_instr_o = (state_q == ST_BAD);

endmodule

// File: rtl/subset_cpu_chk.sv
module subset_cpu_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [63:0] pc_o,
  input logic        halted_o,
  input logic        bad_instr_o,
  input logic [3:0]  dbg_sel_i,
  input logic [63:0] dbg_val_o
);

  // R10
  status_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({halted_o, bad_instr_o}));

  // R8
  halt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> (halted_o && $stable(pc_o)));

  // R9
  bad_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_instr_o |=> (bad_instr_o && $stable(pc_o)));

  // R1
  reset_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (pc_o == 64'd0 && !halted_o && !bad_instr_o));

  // R7
  null_view_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_sel_i == 4'hF) |-> (dbg_val_o == 64'd0));

endmodule

bind subset_cpu_core subset_cpu_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pc_o        (pc_o),
  .halted_o    (halted_o),
  .bad_instr_o (bad_instr_o),
  .dbg_sel_i   (dbg_sel_i),
  .dbg_val_o   (dbg_val_o)
);

// File: tb/tb_subset_cpu_core.sv
`timescale 1ns/1ps
module tb_subset_cpu_core;

  localparam int IMEM  = 512;
  localparam int DMEM  = 256;
  localparam int LD_AW = 9;

  logic             clk = 1'b0;
  logic             rst_ni;
  logic             ld_en;
  logic             ld_dmem;
  logic [LD_AW-1:0] ld_addr;
  logic [7:0]       ld_data;
  logic [3:0]       dbg_sel;
  logic [63:0]      dbg_val;
  logic [63:0]      pc;
  logic             halted;
  logic             bad;

  always #2.5 clk = ~clk;

  subset_cpu_core #(.IMEM_BYTES(IMEM), .DMEM_BYTES(DMEM)) dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .ld_en_i     (ld_en),
    .ld_dmem_i   (ld_dmem),
    .ld_addr_i   (ld_addr),
    .ld_data_i   (ld_data),
    .dbg_sel_i   (dbg_sel),
    .dbg_val_o   (dbg_val),
    .pc_o        (pc),
    .halted_o    (halted),
    .bad_instr_o (bad)
  );

  int          n_chk  = 0;
  int          n_fail = 0;
  bit          done   = 0;
  logic [7:0]  prog [IMEM];
  int          wp;
  logic [63:0] exp_r [16];

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] dm(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  function automatic logic [63:0] ld64(input int a);
    logic [63:0] r;
    for (int k = 0; k < 8; k++) r[8*k +: 8] = dm((a + k) % DMEM);
    return r;
  endfunction

  function automatic logic [63:0] cval(input int i);
    return 64'h0123_4567_89AB_CDEF * 64'(i + 1) + 64'(i);
  endfunction

  task automatic put(input logic [7:0] b);
    prog[wp] = b;
    wp++;
  endtask

  task automatic put64(input logic [63:0] v);
    for (int k = 0; k < 8; k++) put(v[8*k +: 8]);
  endtask

  task automatic e_nop();                put(8'h10); endtask
  task automatic e_halt();               put(8'h00); endtask
  task automatic e_rr(input logic [3:0] a, input logic [3:0] b);
    put(8'h20); put({a, b});
  endtask
  task automatic e_ir(input logic [3:0] b, input logic [63:0] v);
    put(8'h30); put({4'hF, b}); put64(v);
  endtask
  task automatic e_ld(input logic [3:0] a, input logic [3:0] b, input logic [63:0] d);
    put(8'h50); put({a, b}); put64(d);
  endtask
  task automatic e_jmp(input logic [63:0] t);
    put(8'h70); put64(t);
  endtask

  task automatic load_bytes(input bit to_dmem, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ld_en   = 1'b1;
      ld_dmem = to_dmem;
      ld_addr = LD_AW'(i);
      ld_data = to_dmem ? dm(i) : prog[i];
    end
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic run_to_stop(input int max_cyc, output int edges);
    edges = 0;
    while (!halted && !bad && edges < max_cyc) begin
      @(negedge clk);
      edges++;
    end
  endtask

  task automatic check_regs(input string req);
    for (int s = 0; s < 16; s++) begin
      dbg_sel = 4'(s);
      #1;
      check(req, dbg_val, exp_r[s]);
    end
  endtask

  initial begin
    #(5.0 * 190000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int edges;
    logic [63:0] a1;
    rst_ni  = 1'b0;
    ld_en   = 1'b0;
    ld_dmem = 1'b0;
    ld_addr = '0;
    ld_data = '0;
    dbg_sel = '0;
    for (int i = 0; i < IMEM; i++) prog[i] = 8'h00;

    hold_reset();
    load_bytes(1'b1, DMEM);

    // Program A: straight-line coverage of every legal opcode
    wp = 0;
    e_nop();
    for (int i = 0; i < 15; i++) begin
      e_ir(4'(i), cval(i));
      exp_r[i] = cval(i);
    end
    exp_r[15] = 64'd0;
    e_ir(4'hF, 64'hDEAD_BEEF);         // R7 discarded
    e_rr(4'd3, 4'd14);                 // R4
    exp_r[14] = cval(3);
    e_rr(4'hF, 4'd13);                 // R7 null source reads 0
    exp_r[13] = 64'd0;
    e_rr(4'd7, 4'hF);                  // R7 discarded
    e_ld(4'd1, 4'd2, 64'h40);          // R6
    a1 = cval(2) + 64'h40;
    exp_r[1] = ld64(int'(a1[7:0]));
    e_ld(4'd4, 4'hF, 64'd252);         // R6 wrap past top
    exp_r[4] = ld64(252);
    e_ld(4'hF, 4'd5, 64'd0);           // R7 discarded
    e_jmp(64'h1F0);                    // R3
    e_ir(4'd0, 64'h1);                 // skipped
    wp = 'h1F0;
    e_nop();
    e_halt();
    load_bytes(1'b0, IMEM);

    // R1 reset state
    #1;
    check("R1 pc", pc, 64'd0);
    check("R1 halted", 64'(halted), 64'd0);
    check("R1 bad", 64'(bad), 64'd0);
    for (int s = 0; s < 16; s++) begin
      dbg_sel = 4'(s);
      #0.5;
      check("R1 regs", dbg_val, 64'd0);
    end

    release_reset();
    run_to_stop(200, edges);
    check("R2 cycles to halt", 64'(edges), 64'd26);
    check("R8 halted", 64'(halted), 64'd1);
    check("R10 bad low", 64'(bad), 64'd0);
    check("R3 R8 final pc", pc, 64'h1F1);
    repeat (5) @(negedge clk);
    check("R8 pc held", pc, 64'h1F1);
    check("R10 halt sticky", 64'(halted), 64'd1);
    check_regs("R4 R5 R6 R7 R11 regs");

    // R1 reset clears state after a run
    hold_reset();
    #1;
    for (int s = 0; s < 16; s++) begin
      dbg_sel = 4'(s);
      #0.5;
      check("R1 regs cleared", dbg_val, 64'd0);
    end
    check("R1 pc cleared", pc, 64'd0);
    check("R1 halt cleared", 64'(halted), 64'd0);

    // Program B: invalid opcode mid-stream (R9)
    for (int i = 0; i < 32; i++) prog[i] = 8'h00;
    wp = 0;
    e_ir(4'd6, 64'h55);
    e_nop();
    put(8'h21);
    put(8'h66);
    e_ir(4'd6, 64'h99);
    load_bytes(1'b0, 32);
    release_reset();
    run_to_stop(50, edges);
    check("R9 cycles", 64'(edges), 64'd3);
    check("R9 bad", 64'(bad), 64'd1);
    check("R10 halted low", 64'(halted), 64'd0);
    check("R9 pc", pc, 64'd11);
    repeat (4) @(negedge clk);
    check("R9 pc held", pc, 64'd11);
    dbg_sel = 4'd6;
    #1;
    check("R9 no write", dbg_val, 64'h55);

    // Exhaustive opcode-byte sweep (R2 R3 R8 R9)
    for (int op = 0; op < 256; op++) begin
      logic [63:0] epc;
      logic        eh;
      logic        eb;
      hold_reset();
      for (int i = 0; i < 10; i++) prog[i] = 8'h00;
      prog[0] = 8'(op);
      prog[1] = 8'h42;
      load_bytes(1'b0, 10);
      release_reset();
      @(negedge clk);
      eh = 1'b0;
      eb = 1'b0;
      case (op)
        8'h00: begin epc = 64'd0;    eh = 1'b1; end
        8'h10: epc = 64'd1;
        8'h20: epc = 64'd2;
        8'h30: epc = 64'd10;
        8'h50: epc = 64'd10;
        8'h70: epc = 64'h42;
        default: begin epc = 64'd0;  eb = 1'b1; end
      endcase
      check("R2 R3 R9 sweep pc", pc, epc);
      check("R8 sweep halted", 64'(halted), 64'(eh));
      check("R9 R10 sweep bad", 64'(bad), 64'(eb));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule